// File: doc/BRIEF.md
# Chained Secondary Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a main interrupt controller as one level interrupt line. Each source is edge-detected and latched into a pending register. An enable register chooses which pending bits may drive the output. Software reads the pending register to find the active sources. It then acknowledges a source by writing a word with a 0 at that source's bit position.

The number of implemented sources is a parameter that defaults to 32. An instance can be as small as a handful of sources. Unimplemented bit positions read as zero and ignore writes. The register window is 8 bytes wide. Reads return data in the same cycle. A write takes effect at the clock edge on which it is presented. The output line is registered.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset the pending register and the enable register read 0 and irq_o is low.
- R2: Address bit 2 selects the register: 0 (offset 0x00) is the pending register and 1 (offset 0x04) is the enable register. Address bits 1:0 are ignored. Read data reflects the selected register combinationally.
- R3: A 0-to-1 transition of src_i[k] sets pending bit k at the clock edge on which src_i[k] is first sampled high. Holding src_i[k] high does not set the bit again after it has been cleared.
- R4: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged; writing 1 never sets a bit.
- R5: When a rising edge on src_i[k] and a write clearing bit k occur at the same clock edge, bit k ends up set.
- R6: A write to the enable register stores the written bits. A 1 enables the source and a 0 disables it.
- R7: irq_o is high exactly one clock after the AND of pending and enable is non-zero, and low one clock after it becomes zero.
- R8: A pending bit whose enable bit is 0 stays latched and readable but does not drive irq_o.
- R9: Bit positions at or above NUM_SRC read as 0 in both registers and are not affected by writes.
- R10: With bus_sel_i low, bus_we_i has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source lines, synchronous to clk_i |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable, qualified by bus_sel_i |
| bus_addr_i | input | 3 | Byte address inside the 8-byte window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
A pending bit that is wrongly held or lost shows up in two places. It appears in the next combinational read of offset 0x00. It also appears on irq_o one clock after the enable register admits that bit. A stale or corrupted enable bit shows on the read of offset 0x04 in the cycle after the write. It then shows on irq_o one clock later. Because of this, the bench checks irq_o both in the cycle directly after each register change and in the cycle after that. The collision case is read back right after the same edge. A lost set would otherwise stay hidden until the source toggles again.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned SEL_BIT = 2;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sirq_edge_det.sv
module sirq_edge_det #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic         wr_pend_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] en_q;

  // clear-on-zero, then sets override
  always_comb begin
    pend_d = pend_q;
    if (wr_pend_i) pend_d = pend_d & wdata_i;
    pend_d = pend_d | rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_en_i) en_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend_i |=> ((pend_q & ~$past(rise_i) & ~$past(wdata_i)) == '0));

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

  a_r6_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q));
endmodule

// File: rtl/sirq_out.sv
module sirq_out #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_i & en_i);
  end

  assign irq_o = irq_q;

  a_r8_no_enable_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  output logic                irq_o
);
  localparam int unsigned PAD_W = REG_W - NUM_SRC;

  logic [NUM_SRC-1:0] rise_w, pend_w, en_w, rd_val;
  logic               wr_w, wr_pend_w, wr_en_w;
  reg_sel_e           sel_w;

  assign sel_w     = reg_sel_e'(bus_addr_i[SEL_BIT]);
  assign wr_w      = bus_sel_i & bus_we_i;
  assign wr_pend_w = wr_w & (sel_w == SEL_PEND);
  assign wr_en_w   = wr_w & (sel_w == SEL_EN);

  sirq_edge_det #(.N(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (rise_w)
  );

  sirq_regs #(.N(NUM_SRC)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise_w),
    .wr_pend_i (wr_pend_w),
    .wr_en_i   (wr_en_w),
    .wdata_i   (bus_wdata_i[NUM_SRC-1:0]),
    .pend_o    (pend_w),
    .en_o      (en_w)
  );

  sirq_out #(.N(NUM_SRC)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_w),
    .en_i   (en_w),
    .irq_o  (irq_o)
  );

  assign rd_val = (sel_w == SEL_EN) ? en_w : pend_w;

  generate
    if (NUM_SRC < REG_W) begin : g_pad
      assign bus_rdata_o = {{PAD_W{1'b0}}, rd_val};

      a_r9_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[REG_W-1:NUM_SRC] == '0);
    end else begin : g_full
      assign bus_rdata_o = rd_val;
    end
  endgenerate

  a_r7_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(pend_w & en_w))));

  a_r3_set_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_w & ~$past(pend_w) & ~$past(src_i)) == '0));

  a_r10_no_sel_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_sel_i |=> $stable(en_w));
endmodule

// File: tb/sec_irq_ctrl_tb.sv
module sec_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL_N    = 5;

  logic               clk, rst_n;
  logic [31:0]        src_a;
  logic [SMALL_N-1:0] src_b;
  logic               sel, we;
  logic [2:0]         addr;
  logic [31:0]        wdata, rdata_a, rdata_b;
  logic               irq_a, irq_b;
  int                 n_run, n_fail;
  logic [31:0]        v;

  sec_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src_a), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_a), .irq_o(irq_a)
  );

  sec_irq_ctrl #(.NUM_SRC(SMALL_N)) u_small (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src_b), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_b), .irq_o(irq_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // called just after a negedge; returns after the next negedge
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input logic s = 1'b1);
    sel = s; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_a(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata_a;
  endtask

  task automatic rd_b(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata_b;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd_a(3'h0, v); check("R1 pending after reset", v, 32'h0);
    rd_a(3'h4, v); check("R1 enable after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq_a}, 32'h0);
  endtask

  task automatic t_latch_enable();
    src_a[3] = 1'b1;
    step();
    rd_a(3'h0, v); check("R3 rise latches bit3", v, 32'h8);
    check("R8 masked pending no irq", {31'h0, irq_a}, 32'h0);
    bus_wr(3'h4, 32'h8);
    rd_a(3'h4, v); check("R6 enable stored", v, 32'h8);
    check("R7 irq not yet high", {31'h0, irq_a}, 32'h0);
    step();
    check("R7 irq high one clock later", {31'h0, irq_a}, 32'h1);
  endtask

  task automatic t_ack();
    bus_wr(3'h0, 32'hFFFF_FFF7);
    rd_a(3'h0, v); check("R4 zero clears bit3", v, 32'h0);
    check("R7 irq still high right after clear", {31'h0, irq_a}, 32'h1);
    step();
    check("R7 irq low one clock later", {31'h0, irq_a}, 32'h0);
    step();
    rd_a(3'h0, v); check("R3 held level does not re-set", v, 32'h0);
    bus_wr(3'h0, 32'hFFFF_FFFF);
    rd_a(3'h0, v); check("R4 writing ones sets nothing", v, 32'h0);
  endtask

  task automatic t_collision();
    src_a[5] = 1'b1;
    bus_wr(3'h0, 32'hFFFF_FFDF);
    rd_a(3'h0, v); check("R5 set beats clear", v, 32'h20);
  endtask

  task automatic t_no_sel();
    bus_wr(3'h4, 32'h0, 1'b0);
    rd_a(3'h4, v); check("R10 unselected write ignored", v, 32'h8);
  endtask

  task automatic t_multi();
    src_a[0] = 1'b1; src_a[31] = 1'b1;
    step();
    rd_a(3'h0, v); check("R3 two sources latch", v, 32'h8000_0021);
    bus_wr(3'h4, 32'h8000_0000);
    step();
    check("R7 irq from top bit", {31'h0, irq_a}, 32'h1);
    bus_wr(3'h0, 32'h7FFF_FFFF);
    step();
    check("R8 disabled pending leaves irq low", {31'h0, irq_a}, 32'h0);
    rd_a(3'h0, v); check("R8 disabled bits stay latched", v, 32'h21);
    rd_a(3'h3, v); check("R2 low address bits ignored", v, 32'h21);
  endtask

  task automatic t_small();
    bus_wr(3'h4, 32'hFFFF_FFFF);
    rd_b(3'h4, v); check("R9 enable upper bits zero", v, 32'h1F);
    rd_b(3'h7, v); check("R2 offset 0x07 selects enable", v, 32'h1F);
    src_b = '1;
    step();
    rd_b(3'h0, v); check("R9 pending upper bits zero", v, 32'h1F);
    step();
    check("R7 small instance irq", {31'h0, irq_b}, 32'h1);
    bus_wr(3'h0, 32'hFFFF_FFE0);
    rd_b(3'h0, v); check("R4 small instance cleared", v, 32'h0);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    src_a = '0; src_b = '0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_enable();
    t_ack();
    t_collision();
    t_no_sel();
    t_multi();
    t_small();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule